// File: doc/BRIEF.md
# Cluster Shared-Bus Arbiter with Destination-Qualified Grants

This block owns the single shared bus of a compute cluster made of three processing cores and one shared memory. Every core writes outgoing packets into its own small output queue inside the block. A packet holds a 16-bit data word, the id of the destination and the id of the sending core. A core takes part in arbitration whenever its queue is non-empty.

A core is eligible in a cycle only if its head packet can land in that same cycle. For a core destination, that core's input queue must not be full. For the memory, the memory must signal ready. A round-robin arbiter picks one eligible core. Its head packet is driven onto the bus together with a push strobe to exactly one destination, and the packet leaves the output queue at the next clock edge. Because only deliverable packets are granted, a transfer never holds the bus waiting on its target. A core with a blocked packet does not stop the other cores from sending.

Memory loads and stores use the same path as core-to-core messages, addressed with the memory's destination id. The core pipelines, the input queues themselves and the memory array live outside the block. Only the full flags of the input queues and the memory's ready signal come in.

Top module: `clb_cluster_bus`

## Requirements
- R1: After reset all output queues are empty, `outq_full_o` is 0, `grant_o` is 0, `xfer_valid_o` is 0 and no push strobe is active.
- R2: A packet accepted by `send_i` in one cycle can be granted in the very next cycle at the earliest. It is never granted in the cycle it is sent.
- R3: Destination ids 0 to 2 name the cores, and id 3 names the memory. A core is granted only when its head packet's destination is ready. For a core id d that means `inq_full_i[d]` is 0. For id 3 that means `mem_ready_i` is 1. A blocked packet stays at the head of its queue.
- R4: A requester with a blocked destination never prevents an eligible requester from being granted in the same cycle.
- R5: At most one bit of `grant_o` is set in any cycle. Exactly one bit is set whenever at least one core is eligible.
- R6: Priority rotates. After reset core 0 ranks first. After a grant to core i, the ranking starts at core i+1 (wrapping from 2 to 0). The pointer does not move in a cycle without a grant.
- R7: During a grant, `xfer_data_o` and `xfer_dst_o` carry the head packet's data and destination, and `xfer_src_o` carries the granted core's index. Exactly one strobe is raised: `inq_push_o[d]` for a core destination d, or `mem_push_o` for id 3.
- R8: Each output queue holds DEPTH packets (default 4) and delivers them in the order they were sent. `outq_full_o[c]` is 1 while queue c holds DEPTH packets. A send to a full queue is dropped and leaves the stored packets untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | NCORE | Per-core request to enqueue one packet |
| send_data_i | input | NCORE*DATA_W | Data words, core c in bits [c*DATA_W +: DATA_W] |
| send_dst_i | input | NCORE*ID_W | Destination ids, core c in bits [c*ID_W +: ID_W] |
| outq_full_o | output | NCORE | Output queue of core c holds DEPTH packets |
| inq_full_i | input | NCORE | Input queue of core d cannot take a packet |
| mem_ready_i | input | 1 | Shared memory can take a packet this cycle |
| grant_o | output | NCORE | One-hot grant of the bus |
| xfer_valid_o | output | 1 | A packet is on the bus this cycle |
| xfer_data_o | output | DATA_W | Data word of the packet on the bus |
| xfer_dst_o | output | ID_W | Destination id of the packet on the bus |
| xfer_src_o | output | ID_W | Index of the sending core |
| inq_push_o | output | NCORE | Push strobe into the input queue of core d |
| mem_push_o | output | 1 | Push strobe into the shared memory |

## Verification
The assertions assume that the destination readiness inputs are stable between clock edges. They also assume those inputs are a true picture of the targets. A full flag may rise in any cycle, and the block only has to avoid granting into it. The bench changes `send_i`, `inq_full_i` and `mem_ready_i` only on falling edges, and reads outputs one nanosecond later. It uses only destination ids 0 to 3. It overfills a queue on purpose so that the drop path of R8 is exercised, not just assumed.

// File: rtl/clb_pkg.sv
package clb_pkg;

  // upper bound on cores for padded readiness vectors
  localparam int MAX_CORES = 8;

  // next index in a ring of n slots
  function automatic int ring_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // index k steps after start in a ring of n slots
  function automatic int ring_add(input int start, input int k, input int n);
    return (start + k) % n;
  endfunction

  // a destination id is deliverable: cores below ncore, memory at ncore
  function automatic logic dest_ready(input logic [MAX_CORES-1:0] full_pad,
                                      input logic mem_rdy,
                                      input int dst, input int ncore);
    if (dst == ncore) return mem_rdy;
    if (dst < ncore)  return !full_pad[dst];
    return 1'b0;
  endfunction

endpackage

// File: rtl/clb_out_fifo.sv
module clb_out_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  import clb_pkg::*;

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // named internal events
  logic acc_push;
  logic do_pop;

  assign empty_o  = (count == '0);
  assign full_o   = (count == CNT_W'(DEPTH));
  assign acc_push = push_i && !full_o;
  assign do_pop   = pop_i && !empty_o;
  assign head_o   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (acc_push) begin
        store[wr_ptr] <= wdata_i;
        wr_ptr        <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      end
      if (do_pop) rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({acc_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: occupancy never exceeds the capacity
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R8: a send into a full queue without a pop leaves it unchanged
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr) && $stable(rd_ptr)));

  // R3: a pop is only requested with data present
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/clb_rr_arb.sv
module clb_rr_arb #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o
);
  import clb_pkg::*;

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] win_idx;
  logic             any_grant;

  always_comb begin
    grant_o   = '0;
    win_idx   = '0;
    any_grant = 1'b0;
    for (int k = 0; k < N; k++) begin
      automatic int idx = ring_add(int'(ptr), k, N);
      if (!any_grant && elig_i[idx]) begin
        any_grant    = 1'b1;
        grant_o[idx] = 1'b1;
        win_idx      = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (any_grant) ptr <= IDX_W'(ring_next(int'(win_idx), N));
  end

  // R5: never more than one grant
  a_r5_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5/R4: an eligible requester always produces a grant
  a_r5_no_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_i) |-> (|grant_o));

  // R3: grants only go to eligible requesters
  a_r3_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~elig_i) == '0);

  // R6: the priority pointer holds through idle cycles
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant_o) |=> $stable(ptr));

endmodule

// File: rtl/clb_cluster_bus.sv
module clb_cluster_bus #(
  parameter int NCORE  = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int ID_W  = $clog2(NCORE + 1),
  localparam int PKT_W = DATA_W + 2 * ID_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORE-1:0]        send_i,
  input  logic [NCORE*DATA_W-1:0] send_data_i,
  input  logic [NCORE*ID_W-1:0]   send_dst_i,
  output logic [NCORE-1:0]        outq_full_o,
  input  logic [NCORE-1:0]        inq_full_i,
  input  logic                    mem_ready_i,
  output logic [NCORE-1:0]        grant_o,
  output logic                    xfer_valid_o,
  output logic [DATA_W-1:0]       xfer_data_o,
  output logic [ID_W-1:0]         xfer_dst_o,
  output logic [ID_W-1:0]         xfer_src_o,
  output logic [NCORE-1:0]        inq_push_o,
  output logic                    mem_push_o
);
  import clb_pkg::*;

  localparam logic [ID_W-1:0] MEM_ID = ID_W'(NCORE);

  logic [PKT_W-1:0]     head  [NCORE];
  logic [NCORE-1:0]     empty;
  logic [NCORE-1:0]     elig;
  logic [MAX_CORES-1:0] full_pad;

  assign full_pad = MAX_CORES'(inq_full_i);

  // packet layout: {src, dst, data}
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [PKT_W-1:0] wpkt;
    logic [ID_W-1:0]  head_dst;

    assign wpkt = {ID_W'(c), send_dst_i[c*ID_W +: ID_W], send_data_i[c*DATA_W +: DATA_W]};

    clb_out_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (send_i[c]),
      .wdata_i (wpkt),
      .pop_i   (grant_o[c]),
      .head_o  (head[c]),
      .empty_o (empty[c]),
      .full_o  (outq_full_o[c])
    );

    assign head_dst = head[c][DATA_W +: ID_W];
    assign elig[c]  = !empty[c] && dest_ready(full_pad, mem_ready_i, int'(head_dst), NCORE);
  end

  clb_rr_arb #(.N(NCORE)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig_i  (elig),
    .grant_o (grant_o)
  );

  // one-hot select of the granted head packet
  logic [PKT_W-1:0] sel_pkt;
  always_comb begin
    sel_pkt = '0;
    for (int c = 0; c < NCORE; c++)
      if (grant_o[c]) sel_pkt = sel_pkt | head[c];
  end

  assign xfer_valid_o = |grant_o;
  assign xfer_data_o  = sel_pkt[0 +: DATA_W];
  assign xfer_dst_o   = sel_pkt[DATA_W +: ID_W];
  assign xfer_src_o   = sel_pkt[DATA_W + ID_W +: ID_W];

  for (genvar d = 0; d < NCORE; d++) begin : g_dst
    assign inq_push_o[d] = xfer_valid_o && (xfer_dst_o == ID_W'(d));
  end
  assign mem_push_o = xfer_valid_o && (xfer_dst_o == MEM_ID);

  // R3: never push into a full core input queue
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (inq_push_o & inq_full_i) == '0);

  // R3: memory pushes only when memory is ready
  a_r3_mem_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_push_o |-> mem_ready_i);

  // R7: a transfer raises exactly one push strobe
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> $onehot({mem_push_o, inq_push_o}));

  // R1: strobes are silent without a transfer
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid_o |-> ({mem_push_o, inq_push_o} == '0));

endmodule

// File: tb/sim_clb_cluster_bus.sv
`timescale 1ns/1ps
module sim_clb_cluster_bus;
  localparam int NC = 3;
  localparam int DW = 16;
  localparam int DP = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    send_i = '0;
  logic [NC*DW-1:0] send_data_i = '0;
  logic [NC*IW-1:0] send_dst_i = '0;
  logic [NC-1:0]    outq_full_o;
  logic [NC-1:0]    inq_full_i = '0;
  logic             mem_ready_i = 1'b0;
  logic [NC-1:0]    grant_o;
  logic             xfer_valid_o;
  logic [DW-1:0]    xfer_data_o;
  logic [IW-1:0]    xfer_dst_o, xfer_src_o;
  logic [NC-1:0]    inq_push_o;
  logic             mem_push_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  clb_cluster_bus #(.NCORE(NC), .DATA_W(DW), .DEPTH(DP)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // vector: {send[3], dst0, dst1, dst2, inq_full[3], mem_ready, exp_grant[3]}
  localparam logic [15:0] VEC [12] = '{
    {3'b111, 2'd1, 2'd2, 2'd3, 3'b000, 1'b1, 3'b000}, // R2 nothing granted on send
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b001}, // R6 core0 first
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b0, 3'b010}, // R4 core2 blocked, core1 goes
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b0, 3'b000}, // R3 memory not ready
    {3'b001, 2'd3, 2'd0, 2'd0, 3'b000, 1'b0, 3'b000}, // R3 still blocked
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b100}, // R6 pointer at core2
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b001}, // R6 wrap to core0
    {3'b110, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b000}, // R2
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b001, 1'b1, 3'b000}, // R3 core0 input full
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b010}, // R6 core1 ranks first
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b100}, // R5 core2 next
    {3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 1'b1, 3'b000}  // R5 idle
  };

  function automatic logic [IW-1:0] idx_of(input logic [NC-1:0] g);
    for (int i = 0; i < NC; i++) if (g[i]) return IW'(i);
    return '0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 grant", 32'(grant_o), 0);
    chk("R1 valid", 32'(xfer_valid_o), 0);
    chk("R1 outq_full", 32'(outq_full_o), 0);
    chk("R1 strobes", 32'({mem_push_o, inq_push_o}), 0);

    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      send_i      = VEC[v][15:13];
      send_dst_i  = {VEC[v][8:7], VEC[v][10:9], VEC[v][12:11]};
      send_data_i = {16'(32'h2000 + v), 16'(32'h1000 + v), 16'(32'h0000 + v)};
      inq_full_i  = VEC[v][6:4];
      mem_ready_i = VEC[v][3];
      #1;
      chk($sformatf("R3/R4/R5/R6 grant vec%0d", v), 32'(grant_o), 32'(VEC[v][2:0]));
      chk($sformatf("R5 valid vec%0d", v), 32'(xfer_valid_o), 32'(|VEC[v][2:0]));
      if (|VEC[v][2:0])
        chk($sformatf("R7 src vec%0d", v), 32'(xfer_src_o), 32'(idx_of(VEC[v][2:0])));
    end

    // R7 core destination fields
    @(negedge clk);
    send_i = 3'b100; send_data_i = {16'hBEEF, 32'h0}; send_dst_i = {2'd1, 4'd0};
    inq_full_i = '0; mem_ready_i = 1'b1;
    #1 chk("R2 no same-cycle grant", 32'(grant_o), 0);
    @(negedge clk);
    send_i = '0;
    #1;
    chk("R7 grant", 32'(grant_o), 32'b100);
    chk("R7 data", 32'(xfer_data_o), 32'hBEEF);
    chk("R7 dst", 32'(xfer_dst_o), 1);
    chk("R7 src", 32'(xfer_src_o), 2);
    chk("R7 core strobe", 32'({mem_push_o, inq_push_o}), 32'b0010);

    // R7 memory destination fields
    @(negedge clk);
    send_i = 3'b010; send_data_i = {16'h0, 16'h1234, 16'h0}; send_dst_i = {2'd0, 2'd3, 2'd0};
    @(negedge clk);
    send_i = '0;
    #1;
    chk("R7 mem data", 32'(xfer_data_o), 32'h1234);
    chk("R7 mem src", 32'(xfer_src_o), 1);
    chk("R7 mem strobe", 32'({mem_push_o, inq_push_o}), 32'b1000);

    // R8 fill core0 while its destination is blocked
    @(negedge clk);
    inq_full_i = 3'b001; mem_ready_i = 1'b0;
    for (int k = 0; k < DP; k++) begin
      send_i = 3'b001; send_data_i = {32'h0, 16'(32'h0C00 + k)}; send_dst_i = '0;
      @(negedge clk);
    end
    send_i = '0;
    #1;
    chk("R8 full flag", 32'(outq_full_o), 32'b001);
    chk("R3 blocked by full input", 32'(grant_o), 0);
    @(negedge clk);
    send_i = 3'b001; send_data_i = {32'h0, 16'hDEAD};
    @(negedge clk);
    send_i = '0; inq_full_i = '0;
    for (int k = 0; k < DP; k++) begin
      #1 chk($sformatf("R8 order %0d", k), 32'(xfer_data_o), 32'h0C00 + k);
      @(negedge clk);
    end
    #1;
    chk("R8 dropped send", 32'(xfer_valid_o), 0);
    chk("R8 queue drained", 32'(outq_full_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule